// File: doc/BRIEF.md
# Chip-Select Bus Turnaround Timer

This block sits between the access scheduler of a static-memory controller and its chip-select pins. It decides when the next access may begin after the previous one finishes, holding every chip select negated, and so the shared data bus idle, for long enough. A slow device can be given a longer recovery period through a four-bit turnaround field of its own.

The scheduler presents a pending access with a chip-select index, a read/write flag and a flag that marks it as the next read of a split or burst sequence. When enough idle cycles have passed, the block grants the request in that cycle. On the next cycle it drives the selected chip select low. It holds that chip select until the scheduler pulses the end-of-access strobe, and releases it on the following cycle. The idle time needed depends on the access that just finished and on the one now waiting. The turnaround field always comes from the chip select that was just released.

A three-state machine does the control. `ST_FRESH` is the state after reset, with no access on record. `ST_BUSY` means an access is in progress. `ST_GAP` means chip selects are negated and idle cycles are being counted. The transitions are:
- `FRESH_TO_BUSY`, on a grant.
- `BUSY_TO_GAP`, on the end-of-access strobe.
- `GAP_TO_BUSY`, on a grant once the idle count meets the requirement.

Top module: `cst_turnaround_timer`

## Requirements
- R1: After reset all chip selects are high (`cs_n` = 4'hF) and `grant` is low. The first request after reset is granted in the same cycle it is presented, with no added idle time.
- R2: A follow-up access that is not a successive read leaves all chip selects high for at least 2 cycles. When no turnaround applies, it is exactly 2 cycles if the request is already waiting. This covers a read followed by an independent read on the same chip select.
- R3: After a read, a write on any chip select, or a read on a different chip select, gets an idle time of max(2, F+1) cycles. F is the turnaround field of the chip select that just finished.
- R4: A successive read is a read with `req_seq`=1 on the same chip select as a preceding read. It gets an idle time of max(1, F+1) cycles.
- R5: At most one chip select is low at any time.
- R6: `grant` is only asserted while no chip select is low. A request presented while an access is in progress is ignored and leaves `cs_n` unchanged.
- R7: A grant drives chip select `req_cs` low on the next cycle. Bit k of `cs_n` belongs to chip select k, and it stays low until the end-of-access strobe.
- R8: An `acc_done` pulse during an access returns all chip selects high on the next cycle.
- R9: A request that arrives while the idle count is running is held and granted in the exact cycle the requirement is met. A request arriving after the requirement is met is granted at once.
- R10: The turnaround field of chip select k is `bt_cfg[4k+3:4k]`, an unsigned value 0..15.
- R11: After a write, any following access gets exactly the 2-cycle minimum, whatever the turnaround field holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A next access is pending |
| req_cs | input | 2 | Chip-select index of the pending access |
| req_rd | input | 1 | Pending access is a read (1) or write (0) |
| req_seq | input | 1 | Pending access continues a split or burst read sequence |
| acc_done | input | 1 | Strobe in the last active cycle of the current access |
| bt_cfg | input | 16 | Four turnaround fields, 4 bits per chip select |
| grant | output | 1 | Pending access may start; its chip select falls next cycle |
| cs_n | output | 4 | Active-low chip selects |

## Verification
The assertions assume the scheduler pulses `acc_done` only while an access holds a chip select low. They also assume it drops `req_valid` in the cycle after a grant, so that a held request is never mistaken for a second one. The stimulus keeps to this. Each access drops its request at the first falling edge after the grant and raises the end strobe exactly once, in its last busy cycle. The one deliberate exception is a single cycle where a request is raised during an access, to show that it is ignored. Turnaround fields are only changed while no grant decision is pending, or at the moment a new request is presented.

// File: rtl/cst_pkg.sv
package cst_pkg;

    typedef enum logic [1:0] {
        ST_FRESH = 2'd0,
        ST_BUSY  = 2'd1,
        ST_GAP   = 2'd2
    } cst_state_e;

    localparam int IND_FLOOR = 2;
    localparam int SEQ_FLOOR = 1;

endpackage

// File: rtl/cst_need_calc.sv
module cst_need_calc
    import cst_pkg::*;
#(
    parameter int N_CS = 4,
    parameter int BT_W = 4,
    localparam int CSW = (N_CS > 1) ? $clog2(N_CS) : 1,
    localparam int CW  = BT_W + 1
) (
    input  logic [N_CS*BT_W-1:0] cfg,
    input  logic [CSW-1:0]       last_cs,
    input  logic                 last_rd,
    input  logic [CSW-1:0]       nxt_cs,
    input  logic                 nxt_rd,
    input  logic                 nxt_seq,
    output logic [CW-1:0]        need
);

    logic [BT_W-1:0] fld;
    logic [CW-1:0]   stretched;
    logic            seq_case;
    logic            turn_case;

    always_comb begin
        fld       = cfg[last_cs*BT_W +: BT_W];
        stretched = {1'b0, fld} + CW'(1);
        seq_case  = last_rd && nxt_rd && nxt_seq && (nxt_cs == last_cs);
        turn_case = last_rd && (!nxt_rd || (nxt_cs != last_cs));
        if (seq_case) begin
            need = (stretched > CW'(SEQ_FLOOR)) ? stretched : CW'(SEQ_FLOOR);
        end else if (turn_case) begin
            need = (stretched > CW'(IND_FLOOR)) ? stretched : CW'(IND_FLOOR);
        end else begin
            need = CW'(IND_FLOOR);
        end
    end

endmodule

// File: rtl/cst_idle_ctr.sv
module cst_idle_ctr #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          run,
    output logic [CW-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= CW'(1);
        end else if (run && (cnt != '1)) begin
            cnt <= cnt + CW'(1);
        end
    end

endmodule

// File: rtl/cst_cs_drv.sv
module cst_cs_drv #(
    parameter int N_CS = 4,
    localparam int CSW = (N_CS > 1) ? $clog2(N_CS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            open_en,
    input  logic [CSW-1:0]  open_idx,
    input  logic            close_en,
    output logic [N_CS-1:0] cs_n
);

    for (genvar k = 0; k < N_CS; k++) begin : g_pin
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cs_n[k] <= 1'b1;
            end else if (open_en && (open_idx == CSW'(k))) begin
                cs_n[k] <= 1'b0;
            end else if (close_en) begin
                cs_n[k] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/cst_turnaround_timer.sv
module cst_turnaround_timer
    import cst_pkg::*;
#(
    parameter int N_CS = 4,
    parameter int BT_W = 4,
    localparam int CSW = (N_CS > 1) ? $clog2(N_CS) : 1,
    localparam int CW  = BT_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [CSW-1:0]       req_cs,
    input  logic                 req_rd,
    input  logic                 req_seq,
    input  logic                 acc_done,
    input  logic [N_CS*BT_W-1:0] bt_cfg,
    output logic                 grant,
    output logic [N_CS-1:0]      cs_n
);

    cst_state_e     state_q;
    cst_state_e     state_d;
    logic [CSW-1:0] last_cs_q;
    logic           last_rd_q;
    logic [CW-1:0]  need;
    logic [CW-1:0]  idle_cnt;
    logic           finish;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FRESH;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: FRESH_TO_BUSY, BUSY_TO_GAP, GAP_TO_BUSY
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FRESH: if (grant)    state_d = ST_BUSY;
            ST_BUSY:  if (acc_done) state_d = ST_GAP;
            ST_GAP:   if (grant)    state_d = ST_BUSY;
            default:                state_d = ST_FRESH;
        endcase
    end

    // outputs of the machine
    always_comb begin
        grant  = 1'b0;
        finish = 1'b0;
        unique case (state_q)
            ST_FRESH: grant  = req_valid;
            ST_BUSY:  finish = acc_done;
            ST_GAP:   grant  = req_valid && (idle_cnt >= need);
            default: begin
                grant  = 1'b0;
                finish = 1'b0;
            end
        endcase
    end

    // record of the access in flight, taken at its grant
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_cs_q <= '0;
            last_rd_q <= 1'b0;
        end else if (grant) begin
            last_cs_q <= req_cs;
            last_rd_q <= req_rd;
        end
    end

    cst_need_calc #(.N_CS(N_CS), .BT_W(BT_W)) u_need (
        .cfg     (bt_cfg),
        .last_cs (last_cs_q),
        .last_rd (last_rd_q),
        .nxt_cs  (req_cs),
        .nxt_rd  (req_rd),
        .nxt_seq (req_seq),
        .need    (need)
    );

    cst_idle_ctr #(.CW(CW)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (finish),
        .run   (state_q == ST_GAP),
        .cnt   (idle_cnt)
    );

    cst_cs_drv #(.N_CS(N_CS)) u_pins (
        .clk      (clk),
        .rst_n    (rst_n),
        .open_en  (grant),
        .open_idx (req_cs),
        .close_en (finish),
        .cs_n     (cs_n)
    );

endmodule

// File: rtl/cst_turnaround_timer_chk.sv
module cst_turnaround_timer_chk #(
    parameter int N_CS = 4,
    localparam int CSW = (N_CS > 1) ? $clog2(N_CS) : 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [CSW-1:0]  req_cs,
    input logic            req_seq,
    input logic            acc_done,
    input logic            grant,
    input logic [N_CS-1:0] cs_n
);

    logic [5:0] hi_cnt;
    logic       seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt <= '0;
            seen   <= 1'b0;
        end else begin
            if (!(&cs_n)) begin
                hi_cnt <= '0;
                seen   <= 1'b1;
            end else if (hi_cnt != '1) begin
                hi_cnt <= hi_cnt + 6'd1;
            end
        end
    end

    // R5
    one_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R6
    grant_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> (&cs_n));

    // R7
    grant_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> ((~cs_n) == (N_CS'(1) << $past(req_cs))));

    // R8
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_done && !(&cs_n)) |=> (&cs_n));

    // R2
    indep_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && seen && !req_seq) |-> (hi_cnt >= 6'd1));

    // R1
    first_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!seen && (&cs_n) && req_valid) |-> grant);

endmodule

bind cst_turnaround_timer cst_turnaround_timer_chk #(.N_CS(N_CS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_cs    (req_cs),
    .req_seq   (req_seq),
    .acc_done  (acc_done),
    .grant     (grant),
    .cs_n      (cs_n)
);

// File: tb/cst_turnaround_timer_tb.sv
`timescale 1ns/1ps
module cst_turnaround_timer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_cs = '0;
    logic        req_rd = 1'b0;
    logic        req_seq = 1'b0;
    logic        acc_done = 1'b0;
    logic [15:0] bt_cfg = '0;
    logic        grant;
    logic [3:0]  cs_n;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        int    cs;
        int    gap;
        int    len;
        string tag;
    } item_t;

    item_t exp_q[$];
    item_t cur;

    always #2.5 clk = ~clk;

    cst_turnaround_timer u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cs(req_cs),
        .req_rd(req_rd), .req_seq(req_seq), .acc_done(acc_done),
        .bt_cfg(bt_cfg), .grant(grant), .cs_n(cs_n)
    );

    task automatic check(bit ok, string tag, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_bt(int cs, int val);
        bt_cfg[cs*4 +: 4] = 4'(val);
    endtask

    // driver: one access; called at the first negedge of the idle gap
    task automatic run_acc(int cs, bit rd, bit seq, int len, int dly,
                           int exp_gap, string tag, bit probe);
        item_t it;
        repeat (dly) @(negedge clk);
        it.cs = cs; it.gap = exp_gap; it.len = len; it.tag = tag;
        exp_q.push_back(it);
        req_cs = 2'(cs); req_rd = rd; req_seq = seq; req_valid = 1'b1;
        #1;
        if (exp_gap < 0) check(grant == 1'b1, "R1 first grant", int'(grant), 1);
        while (!grant) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        req_valid = 1'b0;
        if (probe) begin
            req_valid = 1'b1;
            req_cs = 2'(cs + 1);
            #1;
            check(grant == 1'b0, "R6 grant during access", int'(grant), 0);
        end
        repeat (len - 1) begin
            @(negedge clk);
            req_valid = 1'b0;
            if (probe) begin
                check(cs_n == ~(4'b1 << cs), "R6 cs unchanged", int'(cs_n),
                      int'(~(4'b1 << cs)));
                probe = 1'b0;
            end
        end
        acc_done = 1'b1;
        @(negedge clk);
        acc_done = 1'b0;
        #1;
        check(cs_n == 4'hF, "R8 release", int'(cs_n), 15);
    endtask

    // monitor: pops expected items as chip selects fall and rise
    logic [3:0] prev_cs = 4'hF;
    int hi_n  = 0;
    int low_n = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_cs = 4'hF;
            hi_n = 0;
        end else begin
            if (cs_n == 4'hF) begin
                if (prev_cs != 4'hF)
                    check(low_n == cur.len, {"R7 active length ", cur.tag}, low_n, cur.len);
                hi_n++;
            end else begin
                if (prev_cs == 4'hF) begin
                    int idx;
                    idx = -1;
                    for (int k = 0; k < 4; k++) if (!cs_n[k]) idx = k;
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R7 unexpected access", idx, -1);
                    end else begin
                        cur = exp_q.pop_front();
                        check(idx == cur.cs, {"R7 select ", cur.tag}, idx, cur.cs);
                        if (cur.gap >= 0)
                            check(hi_n == cur.gap, {"gap ", cur.tag}, hi_n, cur.gap);
                    end
                    low_n = 1;
                end else begin
                    low_n++;
                end
                hi_n = 0;
            end
            prev_cs = cs_n;
        end
    end

    initial begin
        #(100000 * 5);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(cs_n == 4'hF, "R1 reset cs_n", int'(cs_n), 15);
        check(grant == 1'b0, "R1 reset grant", int'(grant), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(cs_n == 4'hF, "R1 idle after reset", int'(cs_n), 15);

        run_acc(0, 1, 0, 3, 0, -1, "R1 first", 0);
        run_acc(0, 1, 1, 2, 0, 1,  "R4 seq f0", 0);
        set_bt(0, 3);
        run_acc(0, 1, 1, 2, 0, 4,  "R4 seq f3", 0);
        run_acc(0, 1, 0, 2, 0, 2,  "R2 rd-rd same cs", 0);
        run_acc(0, 0, 0, 2, 0, 4,  "R3 rd-wr", 0);
        run_acc(0, 0, 0, 2, 0, 2,  "R11 wr-wr", 0);
        run_acc(1, 1, 0, 4, 0, 2,  "R11 wr-rd other cs", 1);
        set_bt(1, 5);
        run_acc(2, 1, 0, 2, 0, 6,  "R3 R10 cs1 field", 0);
        set_bt(2, 1);
        run_acc(2, 1, 1, 2, 0, 2,  "R4 seq f1", 0);
        set_bt(2, 0);
        run_acc(2, 1, 1, 2, 0, 1,  "R4 seq floor", 0);
        set_bt(2, 9);
        run_acc(2, 0, 0, 3, 0, 10, "R3 rd-wr f9", 0);
        set_bt(2, 15);
        run_acc(3, 1, 0, 2, 0, 2,  "R11 wr ignores f15", 0);
        set_bt(3, 15);
        run_acc(3, 1, 1, 2, 0, 16, "R9 R10 held seq f15", 0);
        set_bt(3, 1);
        run_acc(0, 0, 0, 2, 5, 6,  "R9 late request", 0);
        run_acc(1, 1, 1, 2, 0, 2,  "R11 wr-seq", 0);
        set_bt(1, 3);
        run_acc(2, 1, 1, 2, 0, 4,  "R3 seq other cs", 0);
        set_bt(2, 0);
        run_acc(2, 1, 1, 1, 0, 1,  "R4 single-cycle", 0);

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R7 all accesses seen", exp_q.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule